// File: doc/BRIEF.md
# Watchdog Unlock-Protected Register Front End

This block sits between a host bus and a watchdog countdown engine. It decodes a small memory-mapped window (byte address, write data, access size, write and read strobes) plus two side registers, one for configuration and one for locking. From them it drives everything the countdown engine needs: the two stage preload values, a one-cycle reload pulse, a one-cycle pulse that clears the previous-reboot flag, and the enable, free-run, prescale, interrupt-type and reboot-enable levels.

Writes that touch the preloads or the reload/flag-clear control are guarded. A host must first write 0x80 and then 0x86 to offset 0x0C. After that exactly one further write is considered. If it has the right size and targets a guarded register, it takes effect. Either way, the guard closes again. The lock register carries a sticky lock bit: once it is set, the enable and free-run levels, and the lock bit itself, are frozen until reset. The counting itself is done elsewhere.

Top module: `wdt_regif`

## Requirements
- R1: After reset both preloads are 0xFFFFF, reboot is enabled, the slow prescale is selected, the interrupt type is 0, enable, free-run and lock are 0, and the guard is closed.
- R2: A write of 0x80 to offset 0x0C followed by a write of 0x86 to offset 0x0C opens the guard. Without this sequence no guarded write has any effect.
- R3: With the guard open, a 32-bit write (size code 2) to offset 0x00 loads the stage-1 preload, and one to offset 0x04 loads the stage-2 preload. Only data bits 19:0 are kept.
- R4: With the guard open, a 16-bit write (size code 1) to offset 0x0C with data bit 8 set makes `reloadPulse` high for exactly the one cycle after the write.
- R5: The same guarded 16-bit write with data bit 9 or bit 12 set makes `flagClrPulse` high for the one cycle after the write.
- R6: The first write after the guard opens that is not itself an unlock value closes the guard, whether or not it took effect. A second guarded write then needs a new sequence.
- R7: Byte writes (size code 0) of 0x80 and 0x86 advance the unlock sequence. A byte write never performs a guarded write, and a guarded write of the wrong size is dropped.
- R8: A 16-bit read of offset 0x0C returns 0x1200 in `busRdata` on the cycle after the read strobe when `prevRebootFlag` is high, and 0 when it is low. Every other read returns 0.
- R9: A lock-register write sets lock from bit 0, enable from bit 1 and free-run from bit 2, and reads back with the same layout. Once lock is 1, further lock-register writes are ignored.
- R10: A config write sets reboot enable to the inverse of bit 5, fast prescale from bit 2, and interrupt type from bits 1:0. `cfgRdata` returns that same encoding, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset in the mapped window |
| busWdata | input | 32 | Write data |
| busSize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, valid the cycle after `busRd` |
| cfgWr | input | 1 | Config register write strobe |
| cfgWdata | input | 16 | Config write data |
| cfgRdata | output | 16 | Config readback |
| lockWr | input | 1 | Lock register write strobe |
| lockWdata | input | 8 | Lock write data |
| lockRdata | output | 8 | Lock readback |
| prevRebootFlag | input | 1 | Previous-reboot flag from the engine |
| preload1 | output | 20 | Stage-1 preload |
| preload2 | output | 20 | Stage-2 preload |
| reloadPulse | output | 1 | One-cycle reload request |
| flagClrPulse | output | 1 | One-cycle previous-reboot clear |
| enable | output | 1 | Watchdog enable |
| freeRun | output | 1 | Restart after stage 2 |
| lockOut | output | 1 | Lock bit state |
| fastScale | output | 1 | Fast prescale select |
| intType | output | 2 | Stage-1 interrupt type |
| rebootEn | output | 1 | Reboot on stage-2 expiry |

## Verification
Preload writes are swept over sixteen data words whose upper bits are set, so the check shows whether bits above 19 are dropped. The guard is tested in three ways: a write with no sequence, a sequence built from byte writes, and a second write after one consumed access. These show apart a guard that never opens, one that ignores the access size, and one that fails to close. All eight combinations of the reload and flag-clear bits are applied, which separates the two pulses and the two aliased clear bits. All 64 values of the low config bits are swept. Then every lock pattern is applied before and after the lock is set.

// File: rtl/wdt_regif_pkg.sv
package wdt_regif_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int PRE_W = 20;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_PRE1 = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PRE2 = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'hC;
  localparam logic [7:0] KEY_FIRST = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  typedef enum logic [1:0] {GUARD_SHUT = 2'd0, GUARD_HALF = 2'd1, GUARD_OPEN = 2'd2} guard_t;

  typedef struct packed {
    logic ldPre1;
    logic ldPre2;
    logic reloadReq;
    logic clrReq;
  } strobe_t;
endpackage

// File: rtl/wdt_regif_ctrl.sv
module wdt_regif_ctrl
  import wdt_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busSize,
  input  logic              busWr,
  output strobe_t           strobes
);
  guard_t guardQ, guardD;
  logic [DATA_W-1:0] sizedData;
  logic isFirstKey, isSecondKey;

  always_comb begin
    case (busSize)
      SZ_BYTE: sizedData = {24'd0, busWdata[7:0]};
      SZ_HALF: sizedData = {16'd0, busWdata[15:0]};
      default: sizedData = busWdata;
    endcase
  end

  assign isFirstKey  = busWr && (busAddr == OFF_CTRL) && (sizedData == {24'd0, KEY_FIRST});
  assign isSecondKey = busWr && (busAddr == OFF_CTRL) && (sizedData == {24'd0, KEY_SECOND})
                       && (guardQ == GUARD_HALF);

  always_comb begin
    guardD  = guardQ;
    strobes = '0;
    if (isFirstKey) begin
      guardD = GUARD_HALF;
    end else if (isSecondKey) begin
      guardD = GUARD_OPEN;
    end else if (busWr && guardQ == GUARD_OPEN) begin
      guardD = GUARD_SHUT;
      if (busSize == SZ_WORD) begin
        strobes.ldPre1 = (busAddr == OFF_PRE1);
        strobes.ldPre2 = (busAddr == OFF_PRE2);
      end else if (busSize == SZ_HALF && busAddr == OFF_CTRL) begin
        strobes.reloadReq = busWdata[8];
        strobes.clrReq    = busWdata[9] | busWdata[12];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) guardQ <= GUARD_SHUT;
    else       guardQ <= guardD;
  end
endmodule

// File: rtl/wdt_regif_dp.sv
module wdt_regif_dp
  import wdt_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busSize,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  input  logic              cfgWr,
  input  logic [15:0]       cfgWdata,
  output logic [15:0]       cfgRdata,
  input  logic              lockWr,
  input  logic [7:0]        lockWdata,
  output logic [7:0]        lockRdata,
  input  logic              prevRebootFlag,
  output logic [PRE_W-1:0]  preload1,
  output logic [PRE_W-1:0]  preload2,
  output logic              reloadPulse,
  output logic              flagClrPulse,
  output logic              enable,
  output logic              freeRun,
  output logic              lockOut,
  output logic              fastScale,
  output logic [1:0]        intType,
  output logic              rebootEn
);
  localparam logic [PRE_W-1:0] PRE_RESET = '1;
  localparam logic [DATA_W-1:0] FLAG_WORD = 32'h0000_1200;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preload1     <= PRE_RESET;
      preload2     <= PRE_RESET;
      reloadPulse  <= 1'b0;
      flagClrPulse <= 1'b0;
      busRdata     <= '0;
    end else begin
      if (strobes.ldPre1) preload1 <= busWdata[PRE_W-1:0];
      if (strobes.ldPre2) preload2 <= busWdata[PRE_W-1:0];
      reloadPulse  <= strobes.reloadReq;
      flagClrPulse <= strobes.clrReq;
      busRdata     <= (busRd && busAddr == OFF_CTRL && busSize == SZ_HALF && prevRebootFlag)
                      ? FLAG_WORD : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rebootEn  <= 1'b1;
      fastScale <= 1'b0;
      intType   <= 2'd0;
    end else if (cfgWr) begin
      rebootEn  <= ~cfgWdata[5];
      fastScale <= cfgWdata[2];
      intType   <= cfgWdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockOut <= 1'b0;
      enable  <= 1'b0;
      freeRun <= 1'b0;
    end else if (lockWr && !lockOut) begin
      lockOut <= lockWdata[0];
      enable  <= lockWdata[1];
      freeRun <= lockWdata[2];
    end
  end

  assign cfgRdata  = {10'd0, ~rebootEn, 2'd0, fastScale, intType};
  assign lockRdata = {5'd0, freeRun, enable, lockOut};
endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busSize,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  input  logic              cfgWr,
  input  logic [15:0]       cfgWdata,
  output logic [15:0]       cfgRdata,
  input  logic              lockWr,
  input  logic [7:0]        lockWdata,
  output logic [7:0]        lockRdata,
  input  logic              prevRebootFlag,
  output logic [PRE_W-1:0]  preload1,
  output logic [PRE_W-1:0]  preload2,
  output logic              reloadPulse,
  output logic              flagClrPulse,
  output logic              enable,
  output logic              freeRun,
  output logic              lockOut,
  output logic              fastScale,
  output logic [1:0]        intType,
  output logic              rebootEn
);
  strobe_t strobes;

  wdt_regif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busSize(busSize), .busWr(busWr), .strobes(strobes)
  );

  wdt_regif_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .busSize(busSize), .busRd(busRd), .busRdata(busRdata),
    .cfgWr(cfgWr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .lockWr(lockWr), .lockWdata(lockWdata), .lockRdata(lockRdata),
    .prevRebootFlag(prevRebootFlag), .preload1(preload1), .preload2(preload2),
    .reloadPulse(reloadPulse), .flagClrPulse(flagClrPulse), .enable(enable),
    .freeRun(freeRun), .lockOut(lockOut), .fastScale(fastScale),
    .intType(intType), .rebootEn(rebootEn)
  );
endmodule

// File: rtl/wdt_regif_chk.sv
module wdt_regif_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  busAddr,
  input logic [31:0] busWdata,
  input logic [1:0]  busSize,
  input logic        busWr,
  input logic        busRd,
  input logic [31:0] busRdata,
  input logic [19:0] preload1,
  input logic        reloadPulse,
  input logic        lockOut,
  input logic        enable,
  input logic        freeRun
);
  a_r4_reload_single: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |=> !reloadPulse);

  a_r4_reload_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reloadPulse) |-> $past(busWr && busSize == 2'd1 && busAddr == 4'hC && busWdata[8]));

  a_r3_preload_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(preload1) |-> $past(busWr && busSize == 2'd2 && busAddr == 4'h0));

  a_r9_lock_freeze: assert property (@(posedge clk) disable iff (!rstN)
    lockOut |=> (lockOut && $stable(enable) && $stable(freeRun)));

  a_r8_other_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr != 4'hC) |=> (busRdata == 32'd0));
endmodule

bind wdt_regif wdt_regif_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
  .busSize(busSize), .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
  .preload1(preload1), .reloadPulse(reloadPulse), .lockOut(lockOut),
  .enable(enable), .freeRun(freeRun)
);

// File: tb/wdt_regif_tb.sv
module wdt_regif_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [1:0] busSize = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busRdata;
  logic cfgWr = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic lockWr = 1'b0;
  logic [7:0] lockWdata = '0;
  logic [7:0] lockRdata;
  logic prevRebootFlag = 1'b0;
  logic [19:0] preload1, preload2;
  logic reloadPulse, flagClrPulse, enable, freeRun, lockOut, fastScale, rebootEn;
  logic [1:0] intType;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wdt_regif u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    busAddr = a; busWdata = d; busSize = s; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [1:0] s);
    @(negedge clk);
    busAddr = a; busSize = s; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic openGuard(input logic [1:0] s);
    busWrite(4'hC, 32'h80, s);
    busWrite(4'hC, 32'h86, s);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [19:0] exp1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", preload1, 20'hFFFFF);
    check("R1", preload2, 20'hFFFFF);
    check("R1", rebootEn, 1);
    check("R1", fastScale, 0);
    check("R1", intType, 0);
    check("R1", lockRdata, 0);
    check("R1", cfgRdata, 0);
    // R2 no sequence: guarded write dropped
    busWrite(4'h0, 32'h00012345, 2'd2);
    check("R2", preload1, 20'hFFFFF);
    openGuard(2'd1);
    busWrite(4'h0, 32'h12345678, 2'd2);
    check("R3", preload1, 20'h45678);
    exp1 = 20'h45678;
    // R6 guard closed after one access
    busWrite(4'h0, 32'h0000AAAA, 2'd2);
    check("R6", preload1, exp1);
    // R3 sweep stage-2 preload
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = (i * 32'h11111) ^ 32'hABC0_0000 ^ (i << 28);
      openGuard(2'd2);
      busWrite(4'h4, v, 2'd2);
      check("R3", preload2, v & 32'hFFFFF);
      check("R3", preload1, exp1);
    end
    // R7 byte-built unlock works
    openGuard(2'd0);
    busWrite(4'h0, 32'h00033333, 2'd2);
    check("R7", preload1, 20'h33333);
    // R7 byte access never performs, and closes guard
    openGuard(2'd1);
    busWrite(4'h0, 32'h00000001, 2'd0);
    check("R7", preload1, 20'h33333);
    busWrite(4'h0, 32'h00044444, 2'd2);
    check("R7", preload1, 20'h33333);
    // R7 wrong size (half to preload) dropped
    openGuard(2'd1);
    busWrite(4'h0, 32'h00005555, 2'd1);
    check("R7", preload1, 20'h33333);
    // R4/R5 all combinations of bits 8, 9, 12
    for (int m = 0; m < 8; m++) begin
      logic [31:0] d;
      d = (m[0] ? 32'h100 : 0) | (m[1] ? 32'h200 : 0) | (m[2] ? 32'h1000 : 0);
      openGuard(2'd1);
      busWrite(4'hC, d, 2'd1);
      check("R4", reloadPulse, m[0]);
      check("R5", flagClrPulse, m[1] | m[2]);
      @(negedge clk);
      check("R4", reloadPulse, 0);
      check("R5", flagClrPulse, 0);
    end
    // R2 reload without sequence ignored
    busWrite(4'hC, 32'h1300, 2'd1);
    check("R2", reloadPulse, 0);
    check("R2", flagClrPulse, 0);
    // R8 reads
    prevRebootFlag = 1'b1;
    busRead(4'hC, 2'd1);
    check("R8", busRdata, 32'h1200);
    busRead(4'hC, 2'd2);
    check("R8", busRdata, 0);
    busRead(4'h0, 2'd1);
    check("R8", busRdata, 0);
    busRead(4'h4, 2'd2);
    check("R8", busRdata, 0);
    prevRebootFlag = 1'b0;
    busRead(4'hC, 2'd1);
    check("R8", busRdata, 0);
    // R10 config sweep
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      cfgWdata = 16'(c) | 16'hFF00; cfgWr = 1'b1;
      @(negedge clk);
      cfgWr = 1'b0;
      check("R10", rebootEn, !c[5]);
      check("R10", fastScale, c[2]);
      check("R10", intType, c[1:0]);
      check("R10", cfgRdata, c & 32'h27);
    end
    // R9 lock patterns with lock clear
    for (int v = 0; v < 8; v += 2) begin
      @(negedge clk);
      lockWdata = 8'(v); lockWr = 1'b1;
      @(negedge clk);
      lockWr = 1'b0;
      check("R9", enable, v[1]);
      check("R9", freeRun, v[2]);
      check("R9", lockRdata, v);
    end
    @(negedge clk);
    lockWdata = 8'h03; lockWr = 1'b1;
    @(negedge clk);
    lockWr = 1'b0;
    check("R9", lockRdata, 3);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      lockWdata = 8'(v); lockWr = 1'b1;
      @(negedge clk);
      lockWr = 1'b0;
      check("R9", lockRdata, 3);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule